// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock calendar time: seconds, minutes, hours, a day-of-week counter, day of month, month and a two-digit year. It advances by exactly one second on every clock cycle in which the one-second tick enable input is high. The tick comes from an external prescaler. All carries between fields resolve in that same cycle, so software never sees a partly updated calendar.

Software reaches the block through a small word-addressed register bus. Each time field sits in its own 32-bit word, and reads of these words are combinational. A control word holds a halt bit. Software sets the halt bit, writes the new time one field at a time, and clears the bit to resume counting. The month length follows the calendar rules, including February in leap years. The year field runs from 0 to 99 and then wraps to 0. Year 0 is deliberately treated as a common year.

Top module: `cal_tod_counter`

## Requirements
- R1: After synchronous active-low reset, the calendar reads year 1, month 1, day of month 1, day of week 0, 00:00:00, and the halt bit reads 0.
- R2: Field words sit at byte address 0x40 + 4*k: year k=0, month k=1, day of month k=2, day of week k=3, hour k=4, minute k=5, second k=6. The control word is at 0x20, with the halt bit in bit 0. A field read returns the value in bits 7:0 with zeros above. Any other address reads as 0.
- R3: A bus write to a field word stores bits 7:0 of the write data at the next clock edge and discards the upper bits.
- R4: While the halt bit is 1, a tick changes no field. After the bit is cleared, the next tick advances the time again.
- R5: On a tick, seconds count up and wrap 59 to 0, carrying into minutes. Minutes wrap 59 to 0, carrying into hours.
- R6: When hours wrap 23 to 0, both day of month and day of week advance. Day of week counts 0 to 6 and wraps to 0.
- R7: Day of month wraps to 1 and carries into the month after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12.
- R8: February ends after day 29 when the year is a nonzero multiple of 4. It ends after day 28 otherwise, and this includes year 0.
- R9: Month wraps 12 to 1 and carries into the year. The year wraps 99 to 0.
- R10: Every field changes at the same clock edge as the tick that causes the change. With no tick and no write, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse that advances the calendar by one second |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
A wrong carry or a wrong month length shows up on the port at the first tick that crosses that boundary. From then on, every later read of the affected word is off. For this reason, every month of every one of the 100 years is driven across both its last day and the day before its last day, and the snapshot is read right after the tick. A halt bit that leaks, or a field that moves with no tick, shows up as a changed read value within one cycle.

// File: rtl/cal_pkg.sv
// Shared types and helpers for the calendar counter.
// Assumes every time field fits in FIELD_W bits, stored as a binary value.
package cal_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 7;

    // Field index order on the bus; the address of each word depends on it.
    localparam int IDX_YEAR = 0;
    localparam int IDX_MON  = 1;
    localparam int IDX_DOM  = 2;
    localparam int IDX_DOW  = 3;
    localparam int IDX_HOUR = 4;
    localparam int IDX_MIN  = 5;
    localparam int IDX_SEC  = 6;

    typedef logic [FIELD_W-1:0] fld_t;

    // Packed so that the year sits in the most significant byte (index 0).
    typedef struct packed {
        fld_t year;
        fld_t mon;
        fld_t dom;
        fld_t dow;
        fld_t hour;
        fld_t min;
        fld_t sec;
    } cal_time_t;

    localparam fld_t SEC_LAST   = 8'd59;
    localparam fld_t MIN_LAST   = 8'd59;
    localparam fld_t HOUR_LAST  = 8'd23;
    localparam fld_t DOW_LAST   = 8'd6;
    localparam fld_t MON_LAST   = 8'd12;
    localparam fld_t YEAR_LAST  = 8'd99;
    localparam fld_t ZERO_START = 8'd0;
    localparam fld_t ONE_START  = 8'd1;

    // Increment with wrap; values at or above the limit also wrap.
    function automatic fld_t bump(fld_t v, fld_t last, fld_t first);
        return (v >= last) ? first : fld_t'(v + 1'b1);
    endfunction

    // Value a field takes in reset.
    function automatic fld_t reset_value(int idx);
        case (idx)
            IDX_YEAR, IDX_MON, IDX_DOM: return ONE_START;
            default:                    return ZERO_START;
        endcase
    endfunction

    // Select a field from the packed time by its bus index.
    function automatic fld_t pick(cal_time_t t, int idx);
        case (idx)
            IDX_YEAR: return t.year;
            IDX_MON:  return t.mon;
            IDX_DOM:  return t.dom;
            IDX_DOW:  return t.dow;
            IDX_HOUR: return t.hour;
            IDX_MIN:  return t.min;
            default:  return t.sec;
        endcase
    endfunction
endpackage

// File: rtl/cal_month_len.sv
// Last day of the month for a month and a two-digit year.
// Assumes: year 0 is a common year, and other multiples of 4 are leap years.
// An out-of-range month is given 31 days.
module cal_month_len
    import cal_pkg::*;
(
    input  fld_t year,
    input  fld_t mon,
    output fld_t last_day
);
    logic leap;

    // Leap-year test restricted to the two-digit year range.
    always_comb leap = (year != '0) && (year[1:0] == 2'b00);

    // Month length lookup.
    always_comb begin
        case (mon)
            8'd2:                    last_day = leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: last_day = 8'd30;
            default:                 last_day = 8'd31;
        endcase
    end
endmodule

// File: rtl/cal_advance.sv
// Combinational one-second step of the calendar, with the full carry chain.
// Assumes: the caller applies the result only on a tick.
// Fields above their limit wrap as if they were at the limit.
module cal_advance
    import cal_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    fld_t last_day;
    logic wrap_sec, wrap_min, wrap_hour, wrap_dom, wrap_mon;

    cal_month_len u_len (
        .year     (cur.year),
        .mon      (cur.mon),
        .last_day (last_day)
    );

    // Carry chain: each stage wraps only when every lower stage wraps.
    always_comb begin
        wrap_sec  = cur.sec >= SEC_LAST;
        wrap_min  = wrap_sec  && (cur.min  >= MIN_LAST);
        wrap_hour = wrap_min  && (cur.hour >= HOUR_LAST);
        wrap_dom  = wrap_hour && (cur.dom  >= last_day);
        wrap_mon  = wrap_dom  && (cur.mon  >= MON_LAST);
    end

    // Next value of every field.
    always_comb begin
        nxt.sec  = bump(cur.sec, SEC_LAST, ZERO_START);
        nxt.min  = wrap_sec  ? bump(cur.min,  MIN_LAST,  ZERO_START) : cur.min;
        nxt.hour = wrap_min  ? bump(cur.hour, HOUR_LAST, ZERO_START) : cur.hour;
        nxt.dow  = wrap_hour ? bump(cur.dow,  DOW_LAST,  ZERO_START) : cur.dow;
        nxt.dom  = wrap_hour ? bump(cur.dom,  last_day,  ONE_START)  : cur.dom;
        nxt.mon  = wrap_dom  ? bump(cur.mon,  MON_LAST,  ONE_START)  : cur.mon;
        nxt.year = wrap_mon  ? bump(cur.year, YEAR_LAST, ZERO_START) : cur.year;
    end
endmodule

// File: rtl/cal_regfile.sv
// Register file: seven field words, the control word and the read mux.
// Assumes: word-aligned byte addresses, a bus write takes precedence over the tick
// for the field it writes, and only bits FIELD_W-1:0 of a field word exist.
module cal_regfile
    import cal_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] TIME_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  cal_time_t         nxt,
    output cal_time_t         cur,
    output logic              stop,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int STRIDE = DATA_W / 8;

    logic [0:NUM_FIELDS-1][FIELD_W-1:0] fld_all;
    logic [NUM_FIELDS-1:0]              hit;
    logic                               ctrl_hit;
    logic                               adv;
    logic                               stop_q;
    logic                               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:FIELD_W];
    assign ctrl_hit     = bus_addr == CTRL_ADDR;
    assign adv          = tick_en && !stop_q;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        localparam logic [ADDR_W-1:0] WORD_ADDR = TIME_BASE + ADDR_W'(STRIDE * i);
        localparam fld_t              RST_VAL   = reset_value(i);
        fld_t q;

        assign hit[i] = bus_addr == WORD_ADDR;

        // Field register: reset, then a bus write, then the tick step.
        always_ff @(posedge clk) begin
            if (!rst_n)                 q <= RST_VAL;
            else if (bus_we && hit[i])  q <= bus_wdata[FIELD_W-1:0];
            else if (adv)               q <= pick(nxt, i);
        end

        assign fld_all[i] = q;
    end

    // Halt bit of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)                  stop_q <= 1'b0;
        else if (bus_we && ctrl_hit) stop_q <= bus_wdata[0];
    end

    // Read mux: unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) bus_rdata[0] = stop_q;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (hit[i]) bus_rdata[FIELD_W-1:0] = fld_all[i];
        end
    end

    assign cur  = cal_time_t'(fld_all);
    assign stop = stop_q;
endmodule

// File: rtl/cal_tod_counter.sv
// Top of the calendar counter: joins the step logic to the register file.
// Assumes: tick_en is synchronous to clk and high for one cycle per second.
module cal_tod_counter
    import cal_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] TIME_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    cal_time_t time_q;
    cal_time_t time_nxt;
    logic      stop_q;

    cal_advance u_adv (
        .cur (time_q),
        .nxt (time_nxt)
    );

    cal_regfile #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .TIME_BASE (TIME_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .nxt       (time_nxt),
        .cur       (time_q),
        .stop      (stop_q),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/cal_tod_checker.sv
// Temporal checks on the calendar state, bound into the top module.
// Assumes: a cycle with no bus write is the only kind in which the tick alone decides the state.
module cal_tod_checker
    import cal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick_en,
    input logic      bus_we,
    input logic      stop,
    input cal_time_t cur
);
    logic step;
    assign step = tick_en && !stop && !bus_we;

    // R4: a halted counter holds every field.
    a_r4_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !bus_we) |=> $stable(cur));

    // R10: nothing moves without a tick or a write.
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !bus_we) |=> $stable(cur));

    // R5: second wrap clears seconds and moves the minute.
    a_r5_sec_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur.sec == SEC_LAST) |=> (cur.sec == '0) && (cur.min != $past(cur.min)));

    // R6: day-of-week wrap at the end of a day.
    a_r6_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur.dow == DOW_LAST && cur.hour == HOUR_LAST && cur.min == MIN_LAST
         && cur.sec == SEC_LAST) |=> (cur.dow == '0) && (cur.hour == '0));

    // R9: the last second of year 99 rolls over to year 0, January 1.
    a_r9_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur.year == YEAR_LAST && cur.mon == MON_LAST && cur.dom == 8'd31
         && cur.hour == HOUR_LAST && cur.min == MIN_LAST && cur.sec == SEC_LAST)
        |=> (cur.year == '0) && (cur.mon == 8'd1) && (cur.dom == 8'd1));
endmodule

bind cal_tod_counter cal_tod_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .bus_we  (bus_we),
    .stop    (stop_q),
    .cur     (time_q)
);

// File: tb/test_cal_tod_counter.sv
module test_cal_tod_counter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    cal_tod_counter i_cal_tod_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] faddr(int k);
        return 8'(8'h40 + 4 * k);
    endfunction

    function automatic logic [55:0] tpack(int y, int mo, int d, int w, int h, int mi, int s);
        return {8'(y), 8'(mo), 8'(d), 8'(w), 8'(h), 8'(mi), 8'(s)};
    endfunction

    function automatic int month_days(int y, int m);
        if (m == 2) return ((y % 4 == 0) && (y != 0)) ? 29 : 28;
        return 30 + ((m + m / 8) % 2);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load(input int y, mo, d, w, h, mi, s);
        wr(faddr(0), 32'(y));  wr(faddr(1), 32'(mo)); wr(faddr(2), 32'(d));
        wr(faddr(3), 32'(w));  wr(faddr(4), 32'(h));  wr(faddr(5), 32'(mi));
        wr(faddr(6), 32'(s));
    endtask

    task automatic snap(output logic [55:0] t);
        logic [31:0] v;
        for (int k = 0; k < 7; k++) begin
            rd(faddr(k), v);
            t[55 - 8*k -: 8] = v[7:0];
        end
    endtask

    task automatic tick1();
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [55:0] t;
        logic [31:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        snap(t);
        check("R1 reset time", 64'(t), 64'(tpack(1, 1, 1, 0, 0, 0, 0)));
        rd(8'h20, v);
        check("R1 halt bit after reset", 64'(v), 64'd0);

        // R2 unmapped addresses read zero
        rd(8'h00, v); check("R2 unmapped 0x00", 64'(v), 64'd0);
        rd(8'h24, v); check("R2 unmapped 0x24", 64'(v), 64'd0);
        rd(8'h5C, v); check("R2 unmapped 0x5C", 64'(v), 64'd0);
        rd(8'h41, v); check("R2 unaligned 0x41", 64'(v), 64'd0);

        // R2 field order: distinct values per word
        load(42, 7, 19, 5, 13, 27, 8);
        snap(t);
        check("R2 field map", 64'(t), 64'(tpack(42, 7, 19, 5, 13, 27, 8)));

        // R3 only the low byte is kept
        wr(faddr(6), 32'hFFFF_FF2A);
        rd(faddr(6), v);
        check("R3 low byte stored", 64'(v), 64'h2A);
        wr(faddr(4), 32'h1234_5611);
        rd(faddr(4), v);
        check("R3 upper bits dropped", 64'(v), 64'h11);

        // R10 idle cycles change nothing
        load(5, 3, 31, 6, 23, 59, 59);
        repeat (20) @(negedge clk);
        snap(t);
        check("R10 idle hold", 64'(t), 64'(tpack(5, 3, 31, 6, 23, 59, 59)));
        // R10 a single tick moves every field at once
        tick1();
        snap(t);
        check("R10 full carry in one tick", 64'(t), 64'(tpack(5, 4, 1, 0, 0, 0, 0)));

        // R4 halt freezes, and clearing the bit resumes counting
        wr(8'h20, 32'h1);
        rd(8'h20, v);
        check("R4 halt bit reads back", 64'(v), 64'd1);
        for (int n = 0; n < 5; n++) tick1();
        snap(t);
        check("R4 frozen while halted", 64'(t), 64'(tpack(5, 4, 1, 0, 0, 0, 0)));
        wr(8'h20, 32'h0);
        tick1();
        snap(t);
        check("R4 resumes after clear", 64'(t), 64'(tpack(5, 4, 1, 0, 0, 0, 1)));

        // R5 second sweep
        for (int s = 0; s < 60; s++) begin
            load(10, 6, 15, 2, 12, 30, s);
            tick1();
            snap(t);
            check("R5 second step", 64'(t),
                  64'(s == 59 ? tpack(10, 6, 15, 2, 12, 31, 0) : tpack(10, 6, 15, 2, 12, 30, s + 1)));
        end
        // R5 minute sweep
        for (int m = 0; m < 60; m++) begin
            load(10, 6, 15, 2, 12, m, 59);
            tick1();
            snap(t);
            check("R5 minute step", 64'(t),
                  64'(m == 59 ? tpack(10, 6, 15, 2, 13, 0, 0) : tpack(10, 6, 15, 2, 12, m + 1, 0)));
        end
        // R6 hour sweep
        for (int h = 0; h < 24; h++) begin
            load(10, 6, 15, 2, h, 59, 59);
            tick1();
            snap(t);
            check("R6 hour step", 64'(t),
                  64'(h == 23 ? tpack(10, 6, 16, 3, 0, 0, 0) : tpack(10, 6, 15, 2, h + 1, 0, 0)));
        end
        // R6 day-of-week sweep
        for (int w = 0; w < 7; w++) begin
            load(10, 6, 15, w, 23, 59, 59);
            tick1();
            snap(t);
            check("R6 weekday step", 64'(t), 64'(tpack(10, 6, 16, (w + 1) % 7, 0, 0, 0)));
        end

        // R7 R8 R9 month ends for every year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int    last;
                string tag;
                last = month_days(y, m);
                tag  = (m == 2) ? "R8 february" : (m == 12) ? "R9 year end" : "R7 month end";
                load(y, m, last - 1, 3, 23, 59, 59);
                tick1();
                snap(t);
                check(tag, 64'(t), 64'(tpack(y, m, last, 4, 0, 0, 0)));
                load(y, m, last, 3, 23, 59, 59);
                tick1();
                snap(t);
                if (m == 12)
                    check(tag, 64'(t), 64'(tpack((y + 1) % 100, 1, 1, 4, 0, 0, 0)));
                else
                    check(tag, 64'(t), 64'(tpack(y, m + 1, 1, 4, 0, 0, 0)));
            end
        end

        finish_run();
    end
endmodule